// File: doc/BRIEF.md
# Vertical Drive Regenerator with Line Window and Free-Run

This block rebuilds vertical drive from the horizontal line rate. It counts line edges since the last vertical pulse and decides, from a 3-bit mode code, how the next pulse is produced. In window modes an incoming separated vertical sync is accepted only once enough lines have passed. If no sync arrives by a format-specific limit, the block starts a pulse by itself. In the free-run mode it ignores sync and repeats at a line count taken from the horizontal-rate setting. A dedicated code parks the output high.

Each vertical pulse lasts a fixed number of half-line intervals, so its duration in time follows the line rate. An invert bit selects the pulse polarity. The line and half-line edges arrive as single-cycle strobes on the system clock, and every line edge is also a half-line edge.

Top module: `vsync_regen`

## Requirements
- R1: After reset the line count is 0, no pulse is active, and the output rests at its idle level (high when invert is 0).
- R2: In window modes (000, 001, 011, 100, 101, 110) a rising edge of the sync input is latched. It is accepted on the next line strobe if the completed line count at that strobe is at least 48. The maximum counts are 1281, 849, 637, 613, 363 and 307 respectively.
- R3: A sync edge seen at a line strobe whose completed count is below 48 is discarded, and it is not acted on later.
- R4: If a window mode reaches its maximum completed count without an accepted sync, the next line strobe starts a pulse by itself. With no sync, the pulse period is therefore the maximum plus one line.
- R5: Mode 010 free-runs with a period of 262, 525, 562 or 750 line strobes for horizontal-rate codes 00, 01, 10 and 11, and ignores the sync input.
- R6: Mode 111 holds the output high whatever the invert bit and the sync input are.
- R7: A pulse stays active for 9 half-line strobes after the one on which it started.
- R8: With invert 0 the active pulse drives the output low and the idle level is high. With invert 1 both levels are swapped.
- R9: A pulse starts on the line strobe that accepts the sync or reaches the limit. The output changes one clock after that strobe, and the line count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle strobe at each line edge |
| half_tick | input | 1 | One-cycle strobe at each half-line edge |
| vsync_in | input | 1 | Separated vertical sync, active high |
| mode | input | 3 | Window, free-run or stop code |
| hrate | input | 2 | Horizontal-rate code selecting the free-run period |
| invert | input | 1 | Output polarity select |
| vd_out | output | 1 | Regenerated vertical drive |

## Verification
A pulse start appears on the output one clock after the clock edge that captures the accepting line strobe. The bench drives each strobe at a falling edge and reads the output at the next falling edge, so it records the start against that exact line number. At the bench's four-clock line cadence, the 9 half-line width is 18 clocks. The bench counts the active cycles it sees and compares the total with 18. The stop and ignore cases are checked at the output on every cycle of the run, not at a single instant.

// File: rtl/vsync_regen.sv
module vsync_regen #(
  parameter int LW           = 11,
  parameter int HW           = 4,
  parameter int WIN_MIN      = 48,
  parameter int PULSE_HALVES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       half_tick,
  input  logic       vsync_in,
  input  logic [2:0] mode,
  input  logic [1:0] hrate,
  input  logic       invert,
  output logic       vd_out
);

  localparam logic [2:0] M_FREE = 3'b010;
  localparam logic [2:0] M_STOP = 3'b111;

  logic [LW-1:0] line_cnt;
  logic [HW-1:0] hcnt;
  logic          vs_d, pend, pulse_on;
  logic [LW-1:0] limit;
  logic          stop, free, win, vs_rise, accept, expire, restart;

  always_comb begin
    case (mode)
      3'b000:  limit = LW'(1281);
      3'b001:  limit = LW'(849);
      3'b011:  limit = LW'(637);
      3'b100:  limit = LW'(613);
      3'b101:  limit = LW'(363);
      3'b110:  limit = LW'(307);
      3'b010: begin
        case (hrate)
          2'b00:   limit = LW'(261);
          2'b01:   limit = LW'(524);
          2'b10:   limit = LW'(561);
          default: limit = LW'(749);
        endcase
      end
      default: limit = '0;
    endcase
  end

  assign stop    = (mode == M_STOP);
  assign free    = (mode == M_FREE);
  assign win     = !stop && !free;
  assign vs_rise = vsync_in && !vs_d;
  assign accept  = line_tick && win && (pend || vs_rise) && (line_cnt >= LW'(WIN_MIN));
  assign expire  = line_tick && !stop && (line_cnt >= limit);
  assign restart = accept || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d     <= 1'b0;
      pend     <= 1'b0;
      line_cnt <= '0;
      pulse_on <= 1'b0;
      hcnt     <= '0;
    end else begin
      vs_d <= vsync_in;
      if (stop) begin
        pend     <= 1'b0;
        line_cnt <= '0;
        pulse_on <= 1'b0;
        hcnt     <= '0;
      end else begin
        if (restart)        line_cnt <= '0;
        else if (line_tick) line_cnt <= line_cnt + 1'b1;

        if (line_tick)            pend <= 1'b0;
        else if (vs_rise && win)  pend <= 1'b1;

        if (restart) begin
          pulse_on <= 1'b1;
          hcnt     <= '0;
        end else if (pulse_on && half_tick) begin
          if (hcnt == HW'(PULSE_HALVES - 1)) begin
            pulse_on <= 1'b0;
            hcnt     <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      end
    end
  end

  assign vd_out = stop ? 1'b1 : (invert ? pulse_on : !pulse_on);

endmodule

module vsync_regen_chk #(
  parameter int LW           = 11,
  parameter int HW           = 4,
  parameter int WIN_MIN      = 48,
  parameter int PULSE_HALVES = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_tick,
  input logic [2:0]    mode,
  input logic          vd_out,
  input logic          pulse_on,
  input logic [LW-1:0] line_cnt,
  input logic [HW-1:0] hcnt
);

  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111) |-> vd_out);

  p_start_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> $past(line_tick));

  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> ($past(line_cnt) >= LW'(WIN_MIN)));

  p_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> (hcnt < HW'(PULSE_HALVES)));

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= LW'(1281));

  p_free_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && line_tick && line_cnt < LW'(261)) |=> (line_cnt == $past(line_cnt) + LW'(1)));

endmodule

bind vsync_regen vsync_regen_chk #(
  .LW(LW), .HW(HW), .WIN_MIN(WIN_MIN), .PULSE_HALVES(PULSE_HALVES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .mode(mode),
  .vd_out(vd_out), .pulse_on(pulse_on), .line_cnt(line_cnt), .hcnt(hcnt)
);

// File: tb/vsync_regen_tb.sv
module vsync_regen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0, half_tick = 1'b0, vsync_in = 1'b0, invert = 1'b0;
  logic [2:0] mode = 3'b110;
  logic [1:0] hrate = 2'b00;
  logic vd_out;

  int n_chk = 0, n_fail = 0;
  int line_idx = 0, first_start = 0, last_start = 0, wcnt = 0, last_width = 0, low_cycles = 0;
  logic prev_act = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  vsync_regen u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .half_tick(half_tick),
    .vsync_in(vsync_in), .mode(mode), .hrate(hrate), .invert(invert), .vd_out(vd_out)
  );

  // {mode, hrate, sync line (0 = none), expected first pulse line}
  localparam logic [26:0] VEC [0:15] = '{
    {3'b110, 2'b00, 11'd100, 11'd100},
    {3'b110, 2'b00, 11'd30,  11'd308},
    {3'b110, 2'b00, 11'd0,   11'd308},
    {3'b101, 2'b00, 11'd200, 11'd200},
    {3'b101, 2'b00, 11'd0,   11'd364},
    {3'b100, 2'b00, 11'd0,   11'd614},
    {3'b011, 2'b00, 11'd0,   11'd638},
    {3'b001, 2'b00, 11'd0,   11'd850},
    {3'b000, 2'b00, 11'd0,   11'd1282},
    {3'b010, 2'b00, 11'd0,   11'd262},
    {3'b010, 2'b01, 11'd0,   11'd525},
    {3'b010, 2'b10, 11'd0,   11'd562},
    {3'b010, 2'b11, 11'd0,   11'd750},
    {3'b010, 2'b00, 11'd100, 11'd262},
    {3'b110, 2'b00, 11'd49,  11'd49},
    {3'b110, 2'b00, 11'd48,  11'd308}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    logic act;
    act = (mode != 3'b111) && (vd_out == invert);
    if (vd_out == 1'b0) low_cycles++;
    if (act && !prev_act) begin
      if (first_start == 0) first_start = line_idx;
      last_start = line_idx;
      wcnt = 1;
    end else if (act) begin
      wcnt++;
    end else if (prev_act) begin
      last_width = wcnt;
    end
    prev_act = act;
  endtask

  task automatic cyc(input logic lt, input logic ht);
    line_tick = lt;
    half_tick = ht;
    @(posedge clk);
    @(negedge clk);
    line_tick = 1'b0;
    half_tick = 1'b0;
    observe();
  endtask

  task automatic line(input logic vs);
    line_idx++;
    vsync_in = vs;
    cyc(1'b1, 1'b1);
    vsync_in = 1'b0;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    rst_n = 1'b1;
    line_idx = 0; first_start = 0; last_start = 0;
    wcnt = 0; last_width = 0; low_cycles = 0; prev_act = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    mode = 3'b110; invert = 1'b0;
    do_reset();
    check(vd_out == 1'b1, "R1 idle after reset", vd_out, 1);
    // R8 idle inverted
    invert = 1'b1;
    cyc(1'b0, 1'b0);
    check(vd_out == 1'b0, "R8 idle level with invert", vd_out, 0);
    invert = 1'b0;

    for (int i = 0; i < 16; i++) begin
      int vs, ex;
      mode = VEC[i][26:24];
      hrate = VEC[i][23:22];
      vs = int'(VEC[i][21:11]);
      ex = int'(VEC[i][10:0]);
      do_reset();
      for (int n = 1; n <= ex + 25; n++) line(vs != 0 && n == vs);
      check(first_start == ex, $sformatf("R2 R3 R4 R5 R9 vector %0d first pulse line", i), first_start, ex);
      check(last_width == 18, $sformatf("R7 vector %0d pulse width in clocks", i), last_width, 18);
    end

    // R4 forced pulse one full window after an accepted sync
    mode = 3'b110; hrate = 2'b00;
    do_reset();
    for (int n = 1; n <= 420; n++) line(n == 100);
    check(first_start == 100, "R2 accepted sync line", first_start, 100);
    check(last_start == 408, "R4 forced pulse after accepted one", last_start, 408);

    // R8 inverted polarity during pulse
    mode = 3'b010; hrate = 2'b00; invert = 1'b1;
    do_reset();
    for (int n = 1; n <= 262; n++) line(1'b0);
    check(vd_out == 1'b1, "R8 active level with invert", vd_out, 1);
    invert = 1'b0;
    do_reset();
    for (int n = 1; n <= 262; n++) line(1'b0);
    check(vd_out == 1'b0, "R8 active level without invert", vd_out, 0);

    // R6 stop mode holds output high
    mode = 3'b111;
    for (int k = 0; k < 2; k++) begin
      invert = logic'(k);
      do_reset();
      for (int n = 1; n <= 400; n++) line(n % 100 == 60);
      check(low_cycles == 0, $sformatf("R6 stop mode low cycles, invert %0d", k), low_cycles, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule